// File: doc/BRIEF.md
# Add/Subtract/Move Execution Unit with Condition Flags

This block is the integer execution stage of a small load-store processor. Each accepted operation moves, adds or subtracts two 32-bit operands. The first operand always comes from a register value. The second comes either from a register value or from a short immediate field that is zero-extended. Either register source can be marked as the hard-wired zero register, and its value is then replaced with 0. The result leaves through a one-entry output register one clock after the operation is accepted.

When an operation asks for it, the unit also updates a four-bit condition flag register. The flags are presented as a 32-bit status word. The flags sit in the top four bits: negative at bit 31, zero at bit 30, carry at bit 29 and overflow at bit 28. Every lower bit reads as zero. Subtraction is computed as A + ~B + 1, so the carry flag is the inverse of a borrow.

Operations enter over a valid/ready interface, and results leave over a second one. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or its content is being taken on the same edge. This means a result that is not taken blocks the next operation and no work is lost. A result stays unchanged until the consumer raises `out_ready`.

Top module: `alu_nzcv`

## Requirements
- R1: Opcode 2'b00 is a move: the result equals the second operand. Opcode 2'b11 is decoded as a move as well.
- R2: Opcode 2'b01 is an addition: the result is A + B modulo 2^32.
- R3: Opcode 2'b10 is a subtraction: the result is A - B modulo 2^32.
- R4: When `in_imm_sel` is 1, the second operand is the 8-bit `in_imm` zero-extended to 32 bits. In that case `in_b` and `in_b_zero` have no effect.
- R5: When `in_a_zero` is 1, the first operand is 0. When `in_b_zero` is 1 and `in_imm_sel` is 0, the second operand is 0.
- R6: An accepted operation with `in_set_flags` = 1 sets status bit 31 to result bit 31, and sets status bit 30 to 1 exactly when the result is zero.
- R7: For an addition with flag update, status bit 29 is the carry out of bit 31. For a subtraction with flag update, it is 1 when A >= B unsigned (no borrow) and 0 otherwise.
- R8: For an addition with flag update, status bit 28 is 1 when A and B share a sign and the result's sign differs from it. For a subtraction, it is 1 when A and B differ in sign and the result's sign differs from A's.
- R9: The status word keeps its value on every edge without an accepted operation that has `in_set_flags` = 1. A move with flag update leaves bits 29 and 28 unchanged.
- R10: Status bits 27..0 always read 0. A synchronous reset clears the status word and `out_valid`.
- R11: `in_ready` = !`out_valid` || `out_ready`. An accepted operation's result appears on `out_data` with `out_valid` high after the very next clock edge. While `out_valid` is high and `out_ready` is low, `out_data` is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_op | input | 2 | Operation code (00/11 move, 01 add, 10 subtract) |
| in_a | input | 32 | First operand register value |
| in_b | input | 32 | Second operand register value |
| in_a_zero | input | 1 | First source is the zero register |
| in_b_zero | input | 1 | Second source is the zero register |
| in_imm_sel | input | 1 | Use immediate instead of second register |
| in_imm | input | 8 | Unsigned immediate field |
| in_set_flags | input | 1 | Update condition flags with this operation |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Result |
| status | output | 32 | Flag word: N=31, Z=30, C=29, V=28, rest zero |

## Verification
The bench builds the unit with its default widths: 32-bit data and an 8-bit immediate. At these widths the sign boundary (0x7FFFFFFF/0x80000000), the all-ones wrap to zero and the largest immediate 0xFF can all be reached as directed cases. Directed cases cover each flag rule and the zero-register and immediate selection. A randomised phase follows, in which the consumer withholds `out_ready` irregularly. That phase drives the back-pressure hold and the blocking of new operations while a result waits.

// File: rtl/alu_nzcv_pkg.sv
package alu_nzcv_pkg;

  typedef enum logic [1:0] {
    OP_MOVE  = 2'b00,
    OP_ADD   = 2'b01,
    OP_SUB   = 2'b10,
    OP_MOVE2 = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } nzcv_t;

  localparam int FLAG_CNT = 4;

  function automatic logic op_is_move(input logic [1:0] op);
    return (op == OP_MOVE) || (op == OP_MOVE2);
  endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input  logic [DATA_W-1:0] a_raw,
  input  logic [DATA_W-1:0] b_raw,
  input  logic              a_zero,
  input  logic              b_zero,
  input  logic              imm_sel,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] a_val,
  output logic [DATA_W-1:0] b_val
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign imm_ext = {{PAD_W{1'b0}}, imm};
    end else begin : g_nopad
      assign imm_ext = imm[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    a_val = a_zero ? '0 : a_raw;
    if (imm_sel) begin
      b_val = imm_ext;
    end else if (b_zero) begin
      b_val = '0;
    end else begin
      b_val = b_raw;
    end
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
    sum   = wide[DATA_W-1:0];
    carry = wide[DATA_W];
    ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_nzcv_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              upd_cv,
  input  nzcv_t             nxt,
  output logic [DATA_W-1:0] status
);
  localparam int LOW_W = DATA_W - FLAG_CNT;

  nzcv_t flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (upd) begin
      flags_q.neg  <= nxt.neg;
      flags_q.zero <= nxt.zero;
      if (upd_cv) begin
        flags_q.carry <= nxt.carry;
        flags_q.ovf   <= nxt.ovf;
      end
    end
  end

  assign status = {flags_q, {LOW_W{1'b0}}};
endmodule

// File: rtl/alu_nzcv.sv
module alu_nzcv
  import alu_nzcv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic              in_a_zero,
  input  logic              in_b_zero,
  input  logic              in_imm_sel,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic              in_set_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [DATA_W-1:0] status
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] a_val, b_val, sum, result;
  logic              carry, ovf, is_move, is_sub, accept;
  nzcv_t             nxt_flags;

  alu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .a_raw  (in_a),
    .b_raw  (in_b),
    .a_zero (in_a_zero),
    .b_zero (in_b_zero),
    .imm_sel(in_imm_sel),
    .imm    (in_imm),
    .a_val  (a_val),
    .b_val  (b_val)
  );

  assign is_move = op_is_move(in_op);
  assign is_sub  = (alu_op_e'(in_op) == OP_SUB);

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a    (a_val),
    .b    (b_val),
    .sub  (is_sub),
    .sum  (sum),
    .carry(carry),
    .ovf  (ovf)
  );

  always_comb begin
    result          = is_move ? b_val : sum;
    nxt_flags.neg   = result[MSB];
    nxt_flags.zero  = (result == '0);
    nxt_flags.carry = carry;
    nxt_flags.ovf   = ovf;
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  alu_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .upd   (accept && in_set_flags),
    .upd_cv(!is_move),
    .nxt   (nxt_flags),
    .status(status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= result;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/alu_nzcv_chk.sv
module alu_nzcv_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_op,
  input logic              in_set_flags,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [DATA_W-1:0] status
);
  localparam int MSB = DATA_W - 1;

  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  logic fire;
  assign fire = in_valid && in_ready;

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r11_next: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);

  a_r9_keep: assert property (@(posedge clk) disable iff (rst)
    !(fire && in_set_flags) |=> $stable(status));

  a_r9_move_cv: assert property (@(posedge clk) disable iff (rst)
    (fire && in_set_flags && (in_op == 2'b00 || in_op == 2'b11))
      |=> (status[MSB-2:MSB-3] == $past(status[MSB-2:MSB-3])));

  a_r6_nz: assert property (@(posedge clk) disable iff (rst)
    (fire && in_set_flags)
      |=> (status[MSB] == out_data[MSB] && status[MSB-1] == (out_data == '0)));

  a_r10_reset: assert property (@(posedge clk)
    rst_d |-> (status == '0 && !out_valid));

  a_r10_low: assert property (@(posedge clk) disable iff (rst)
    status[MSB-4:0] == '0);
endmodule

bind alu_nzcv alu_nzcv_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .in_set_flags(in_set_flags),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .status      (status)
);

// File: tb/alu_nzcv_test.sv
module alu_nzcv_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = '0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        in_a_zero = 1'b0, in_b_zero = 1'b0, in_imm_sel = 1'b0;
  logic [7:0]  in_imm = '0;
  logic        in_set_flags = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data, status;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_nzcv uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_a_zero(in_a_zero),
    .in_b_zero(in_b_zero), .in_imm_sel(in_imm_sel), .in_imm(in_imm),
    .in_set_flags(in_set_flags), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .status(status)
  );

  typedef struct {
    logic [31:0] res;
    logic [31:0] st;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          total = 0;
  int          bad = 0;
  logic [3:0]  mflags = '0;
  bit          bp_on = 0;
  bit          finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                      input bit az, input bit bz, input bit isel, input logic [7:0] imm,
                      input bit sf, input string tag);
    logic [31:0] av, bv, r;
    logic [32:0] w;
    logic        c, v;
    bit          mv;
    item_t       it;
    av = az ? 32'h0 : a;
    bv = isel ? {24'h0, imm} : (bz ? 32'h0 : b);
    mv = (op == 2'b00) || (op == 2'b11);
    c = 1'b0; v = 1'b0;
    if (op == 2'b01) begin
      w = {1'b0, av} + {1'b0, bv};
      r = w[31:0]; c = w[32];
      v = (av[31] == bv[31]) && (r[31] != av[31]);
    end else if (op == 2'b10) begin
      r = av - bv; c = (av >= bv);
      v = (av[31] != bv[31]) && (r[31] != av[31]);
    end else begin
      r = bv;
    end
    if (sf) begin
      mflags[3] = r[31];
      mflags[2] = (r == 32'h0);
      if (!mv) begin
        mflags[1] = c;
        mflags[0] = v;
      end
    end
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_a_zero = az;
    in_b_zero = bz; in_imm_sel = isel; in_imm = imm; in_set_flags = sf;
    while (!in_ready) @(negedge clk);
    it.res = r; it.st = {mflags, 28'h0}; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // consumer back-pressure, changed just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1 out_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  // monitor
  logic        held_v = 1'b0;
  logic [31:0] held_d = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (held_v) check(out_data == held_d, "R11", "held data", out_data, held_d);
        if (out_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R11", "unexpected result", out_data, 32'h0);
          end else begin
            item_t e;
            e = sb.pop_front();
            check(out_data == e.res, e.tag, "result", out_data, e.res);
            check(status == e.st, e.tag, "status", status, e.st);
          end
          held_v = 1'b0;
        end else begin
          held_v = 1'b1; held_d = out_data;
        end
      end else begin
        held_v = 1'b0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(status == 32'h0, "R10", "reset status", status, 32'h0);
    check(out_valid == 1'b0, "R10", "reset out_valid", {31'h0, out_valid}, 32'h0);
    check(in_ready == 1'b1, "R11", "ready when empty", {31'h0, in_ready}, 32'h1);

    send(2'b00, 32'h0, 32'h12345678, 0, 0, 0, 8'h0, 1, "R1");
    send(2'b01, 32'hFFFFFFFF, 32'h1, 0, 0, 0, 8'h0, 1, "R2");
    send(2'b01, 32'h7FFFFFFF, 32'h1, 0, 0, 0, 8'h0, 1, "R8");
    send(2'b01, 32'h80000000, 32'h80000000, 0, 0, 0, 8'h0, 1, "R7");
    send(2'b00, 32'h0, 32'h55, 0, 0, 1, 8'h00, 1, "R9");
    send(2'b10, 32'h5, 32'h5, 0, 0, 0, 8'h0, 1, "R3");
    send(2'b10, 32'h3, 32'h5, 0, 0, 0, 8'h0, 1, "R7");
    send(2'b10, 32'h80000000, 32'h1, 0, 0, 0, 8'h0, 1, "R8");
    send(2'b10, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 0, 0, 8'h0, 1, "R8");
    send(2'b01, 32'h0, 32'h0, 0, 0, 0, 8'h0, 0, "R9");
    send(2'b01, 32'h1, 32'hDEAD0000, 0, 0, 1, 8'hFF, 1, "R4");
    send(2'b10, 32'h1234, 32'h1, 1, 0, 0, 8'h0, 1, "R5");
    send(2'b00, 32'h0, 32'hCAFEF00D, 0, 1, 0, 8'h0, 1, "R5");
    send(2'b11, 32'h0, 32'h80000001, 0, 0, 0, 8'h0, 1, "R1");
    send(2'b00, 32'h0, 32'h0, 0, 1, 1, 8'h80, 1, "R4");
    send(2'b01, 32'hFFFFFF00, 32'h0, 0, 0, 1, 8'hFF, 1, "R6");

    bp_on = 1;
    for (int i = 0; i < 60; i++) begin
      logic [1:0]  op;
      logic [31:0] a, b;
      op = 2'($urandom_range(0, 3));
      a  = $urandom();
      b  = (i % 5 == 0) ? a : $urandom();
      send(op, a, b, ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 3) == 0), 8'($urandom()), ($urandom_range(0, 3) != 0), "R11");
    end
    bp_on = 0;
    repeat (20) @(negedge clk);
    check(sb.size() == 0, "R11", "all results delivered", sb.size(), 32'h0);
    check(status[27:0] == 28'h0, "R10", "low status bits", status, {status[31:28], 28'h0});
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule